// File: doc/BRIEF.md
# Indirect-Access Redirection Register File

This block holds the programmable routing table of an interrupt controller and makes it reachable from a narrow 32-bit register bus through two addresses only: a selector register and a data window. Software writes an index into the selector, then reads or writes the data window to reach the register that the index names. The reachable registers are an 8-bit controller identifier, a read-only version word, a reserved word and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves at neighbouring indices.

The whole table is driven out in parallel on a flat vector so that a downstream dispatcher can use any entry without a bus cycle. Whenever either half of a valid entry is written, the block raises a one-cycle notification so that the dispatcher can rescan the table. Reads complete in the same cycle. Writes take effect at the clock edge.

Top module: `redir_regfile`

## Requirements
- R1: Only offsets 0x00 (selector) and 0x10 (data window) are decoded. A read at any other offset returns zero, and a write there changes no state.
- R2: The selector is 8 bits wide. A write to offset 0x00 stores bits 7:0 of the data, and a read of offset 0x00 returns the selector zero-extended to 32 bits.
- R3: With selector 0x00, the window reads the identifier in bits 31:24 and zeros elsewhere. A write there stores data bits 31:24 as the identifier.
- R4: With selector 0x01, the window reads 0x11 in bits 7:0, ENTRIES-1 (23 by default) in bits 23:16, and zeros elsewhere. Writes to it change no state.
- R5: With selector 0x02, the window reads zero and writes change no state.
- R6: With a selector of 0x10 or above, the entry number is (selector-0x10)>>1. An even selector reaches entry bits 31:0 and an odd selector reaches bits 63:32. A write replaces only that half. Entry n appears on table_flat bits 64n+63:64n.
- R7: A selector whose entry number is ENTRIES or more, or a selector from 0x03 to 0x0F, reads zero through the window, and writes through it change no state.
- R8: After reset every entry is 0x0000_0000_0001_0000 (bit 16 set), and the identifier and the selector are zero.
- R9: table_updated is high for exactly the one cycle after each window write that reaches a valid entry half, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 8 | Low byte of the access address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access, zero otherwise |
| table_flat | output | 64*ENTRIES | All redirection entries, entry n at bits 64n+63:64n |
| table_updated | output | 1 | One-cycle pulse after a write to a valid entry half |

## Verification
On every cycle, the assertions check the following:
- the selector read-back and the fixed version word;
- zero data at undecoded offsets;
- that the table and the identifier hold their values unless the right window write occurs;
- that each update pulse is traced back to a valid entry write.

Only the bench's scenarios can show the rest: that the correct half of the correct entry is replaced, the reset contents, that out-of-range selectors leave the table untouched, and that identifier writes keep only the top byte. These are compared against a reference model of the table.

// File: rtl/redir_regfile.sv
module redir_regfile #(
  parameter int ENTRIES = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [7:0]            bus_offset,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [64*ENTRIES-1:0] table_flat,
  output logic                  table_updated
);
  localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;
  localparam logic [7:0] TOP_ENTRY = 8'(ENTRIES - 1);

  logic [7:0]  sel_q;
  logic [7:0]  id_q;
  logic [63:0] tbl [ENTRIES];

  logic [7:0]    rel;
  logic [6:0]    ent;
  logic [EW-1:0] ent_idx;
  logic          sel_ok;
  logic          sel_wr, win_wr, win_rd, ent_wr;

  assign rel     = sel_q - 8'h10;
  assign ent     = rel[7:1];
  assign ent_idx = ent[EW-1:0];
  assign sel_ok  = (sel_q >= 8'h10) && (int'(ent) < ENTRIES);

  assign sel_wr = bus_valid && bus_write && (bus_offset == 8'h00);
  assign win_wr = bus_valid && bus_write && (bus_offset == 8'h10);
  assign win_rd = bus_valid && !bus_write && (bus_offset == 8'h10);
  assign ent_wr = win_wr && sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q         <= 8'h00;
      id_q          <= 8'h00;
      table_updated <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= ENTRY_RST;
    end else begin
      table_updated <= ent_wr;
      if (sel_wr) sel_q <= bus_wdata[7:0];
      if (win_wr && sel_q == 8'h00) id_q <= bus_wdata[31:24];
      if (ent_wr) begin
        if (sel_q[0]) tbl[ent_idx][63:32] <= bus_wdata;
        else          tbl[ent_idx][31:0]  <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_valid && !bus_write && bus_offset == 8'h00) begin
      bus_rdata = {24'h0, sel_q};
    end else if (win_rd) begin
      case (sel_q)
        8'h00:   bus_rdata = {id_q, 24'h0};
        8'h01:   bus_rdata = {8'h00, TOP_ENTRY, 8'h00, VERSION};
        8'h02:   bus_rdata = 32'h0;
        default: if (sel_ok) bus_rdata = sel_q[0] ? tbl[ent_idx][63:32] : tbl[ent_idx][31:0];
      endcase
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign table_flat[64*g +: 64] = tbl[g];
  end
endmodule

// File: rtl/redir_regfile_chk.sv
module redir_regfile_chk #(
  parameter int ENTRIES = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic [7:0]            bus_offset,
  input logic [31:0]           bus_rdata,
  input logic [64*ENTRIES-1:0] table_flat,
  input logic                  table_updated,
  input logic [7:0]            sel_q,
  input logic [7:0]            id_q
);
  logic [7:0] rel;
  logic       in_range, win_wr, rd;
  assign rel      = sel_q - 8'h10;
  assign in_range = (sel_q >= 8'h10) && (int'(rel[7:1]) < ENTRIES);
  assign win_wr   = bus_valid && bus_write && bus_offset == 8'h10;
  assign rd       = bus_valid && !bus_write;

  // R1
  undecoded_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_offset != 8'h00 && bus_offset != 8'h10) |-> bus_rdata == 32'h0);

  // R2
  sel_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_offset == 8'h00) |-> bus_rdata == {24'h0, sel_q});

  // R3
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_wr && sel_q == 8'h00) |=> $stable(id_q));

  // R4
  version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_offset == 8'h10 && sel_q == 8'h01) |->
      bus_rdata == {8'h00, 8'(ENTRIES - 1), 8'h00, VERSION});

  // R7
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_wr && in_range) |=> $stable(table_flat));

  // R9
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    table_updated |-> $past(win_wr && in_range));
endmodule

bind redir_regfile redir_regfile_chk #(.ENTRIES(ENTRIES), .VERSION(VERSION)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_offset(bus_offset), .bus_rdata(bus_rdata), .table_flat(table_flat),
  .table_updated(table_updated), .sel_q(sel_q), .id_q(id_q)
);

// File: tb/redir_regfile_tb_top.sv
`timescale 1ns/1ps
module redir_regfile_tb_top;
  localparam int N = 24;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_offset = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [64*N-1:0] table_flat;
  logic table_updated;

  redir_regfile #(.ENTRIES(N)) dut_i (.*);

  always #10 clk = ~clk;

  logic [63:0] m_tbl [N];
  logic [7:0] m_sel, m_id;
  int checks = 0, fails = 0;

  function automatic logic sel_valid(logic [7:0] s);
    return s >= 8'h10 && ((int'(s) - 16) >> 1) < N;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] off);
    int e;
    if (off == 8'h00) return {24'h0, m_sel};
    if (off != 8'h10) return 0;
    if (m_sel == 8'h00) return {m_id, 24'h0};
    if (m_sel == 8'h01) return 32'h0017_0011;
    if (!sel_valid(m_sel)) return 0;
    e = (int'(m_sel) - 16) >> 1;
    return m_sel[0] ? m_tbl[e][63:32] : m_tbl[e][31:0];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_table(string req);
    for (int i = 0; i < N; i++) check(req, table_flat[64*i +: 64], m_tbl[i]);
  endtask

  task automatic do_write(logic [7:0] off, logic [31:0] d);
    logic pulse;
    int e;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_offset = off; bus_wdata = d;
    pulse = 0;
    if (off == 8'h00) m_sel = d[7:0];
    else if (off == 8'h10) begin
      if (m_sel == 8'h00) m_id = d[31:24];
      else if (sel_valid(m_sel)) begin
        e = (int'(m_sel) - 16) >> 1;
        if (m_sel[0]) m_tbl[e][63:32] = d; else m_tbl[e][31:0] = d;
        pulse = 1;
      end
    end
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    check("R9 pulse", {63'h0, table_updated}, {63'h0, pulse});
  endtask

  task automatic do_read(logic [7:0] off, string req);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_offset = off;
    #1 check(req, {32'h0, bus_rdata}, {32'h0, exp_read(off)});
    bus_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < N; i++) m_tbl[i] = 64'h1_0000;
    m_sel = 0; m_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    check_table("R8 reset table");
    check("R8 no pulse", {63'h0, table_updated}, 64'h0);
    do_read(8'h00, "R8 sel reset");
    do_read(8'h10, "R8 id reset");
    // R3 identifier keeps top byte
    do_write(8'h10, 32'hA5FF_FFFF);
    do_read(8'h10, "R3 id");
    // R4 version read-only
    do_write(8'h00, 32'hFFFF_FF01);
    do_read(8'h00, "R2 sel low byte");
    do_read(8'h10, "R4 version");
    do_write(8'h10, 32'hDEAD_BEEF);
    do_read(8'h10, "R4 version after write");
    // R5 reserved index
    do_write(8'h00, 32'h02);
    do_write(8'h10, 32'h1234_5678);
    do_read(8'h10, "R5 reserved");
    // R6 halves of last entry
    do_write(8'h00, 8'h10 + 2*(N-1));
    do_write(8'h10, 32'hCAFE_0001);
    do_write(8'h00, 8'h11 + 2*(N-1));
    do_write(8'h10, 32'hBEEF_0002);
    check_table("R6 halves");
    do_read(8'h10, "R6 odd read");
    // R7 out of range and low gap
    do_write(8'h00, 8'h10 + 2*N);
    do_write(8'h10, 32'hFFFF_FFFF);
    do_read(8'h10, "R7 oob read");
    do_write(8'h00, 8'h05);
    do_write(8'h10, 32'hFFFF_FFFF);
    do_read(8'h10, "R7 gap read");
    check_table("R7 table untouched");
    // R1 undecoded offsets
    do_write(8'h04, 32'hFFFF_FFFF);
    do_write(8'h14, 32'hFFFF_FFFF);
    do_read(8'h20, "R1 undecoded read");
    do_read(8'h00, "R1 sel untouched");
    check_table("R1 table untouched");
    // random traffic
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 9);
      logic [7:0] off = (r < 4) ? 8'h00 : (r < 8) ? 8'h10 : 8'($urandom);
      logic [31:0] d = $urandom;
      if (off == 8'h00 && $urandom_range(0, 3) != 0) d[7:0] = 8'($urandom_range(0, 16 + 2*N + 3));
      if ($urandom_range(0, 1)) do_write(off, d);
      else do_read(off, "R6 random read");
    end
    check_table("R6 random table");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule